// File: doc/BRIEF.md
# Byte/Word Flash Host Bus Front End

This block sits between the asynchronous host pins of a parallel flash and the synchronous logic inside it. It samples the chip-enable, output-enable, write-enable, lane-width and host-reset strobes through a parameterised synchronizer chain. It forms the array word address, and it drives read data onto the data pins using per-bit output enables. The pad ring turns these enables into tri-states.

When the lane-width pin is low, the part works one byte at a time. The top data pin is then taken as the least significant bit of the byte address, and it also picks which half of the stored word appears on the low lane. The upper lane is left undriven. When the pin is high, transfers use the full data width.

For write cycles, the address is captured when the qualified write strobe opens and the data when it closes. One write-valid pulse then hands the pair to the command logic.

Top module: `flash_bus_front`

## Requirements
- R1: With chip-enable and output-enable low, host reset high and the lane-width pin high, all bits of `dq_oe_o` are 1 and `dq_o` equals `arr_rdata_i`. `arr_addr_o` always follows `addr_i`.
- R2: With the lane-width pin low during a read, `dq_oe_o` enables only the lower half (16'h00FF at default width). `dq_o` low half is `arr_rdata_i` upper half when `dq_i` top bit is 1, and lower half when it is 0.
- R3: While chip-enable is high, `dq_oe_o` is all zero.
- R4: While output-enable is high, `dq_oe_o` is all zero.
- R5: A write is accepted only while write-enable is low with chip-enable low, output-enable high and host reset high. Each such low-to-high write-enable cycle gives exactly one single-cycle `wr_valid_o` pulse.
- R6: Write-enable cycles made with chip-enable high, or with output-enable low, give no `wr_valid_o` pulse.
- R7: The address is captured when the qualified write strobe opens. In full-width mode `wr_addr_o` = {addr_i, 0}. In byte mode it is {addr_i, dq_i top bit}. Changes to `addr_i` after the strobe opens do not alter it.
- R8: The data is captured when the strobe closes. In full-width mode `wr_data_o` = `dq_i`. In byte mode it is the low half of `dq_i` with the upper half zero, and `wr_byte_o` is 1. `wr_data_o` changes only together with a `wr_valid_o` pulse.
- R9: While host reset is low, `dq_oe_o` is all zero and writes are ignored. A write cycle that reset interrupts produces no pulse.
- R10: After system reset, `wr_valid_o`, `dq_oe_o`, `wr_addr_o` and `wr_data_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | System reset, active low |
| ce_n_i | input | 1 | Host chip enable, active low |
| oe_n_i | input | 1 | Host output enable, active low |
| we_n_i | input | 1 | Host write strobe, active low |
| byte_n_i | input | 1 | Lane width: 0 byte, 1 full word |
| hrst_n_i | input | 1 | Host reset pin, active low |
| addr_i | input | ADDR_W | Host word address |
| dq_i | input | DATA_W | Data pins, input side |
| dq_o | output | DATA_W | Data pins, output side |
| dq_oe_o | output | DATA_W | Per-pin output enable |
| arr_addr_o | output | ADDR_W | Word address to the array |
| arr_rdata_i | input | DATA_W | Word read from the array |
| wr_valid_o | output | 1 | One-cycle write handoff pulse |
| wr_addr_o | output | ADDR_W+1 | Captured byte address |
| wr_data_o | output | DATA_W | Captured write data |
| wr_byte_o | output | 1 | Captured write was a byte write |

## Verification
The bench builds the block with a 19-bit address, a 16-bit data bus and three synchronizer stages. This shows that the behaviour does not depend on the stage count. It also leaves a long enough gap between a strobe edge and its capture for the bench to move the address after capture, and to pull host reset inside an open write. Both lane widths are exercised for reads and writes, including both values of the byte-select bit.

// File: rtl/flash_bus_pkg.sv
package flash_bus_pkg;
   typedef enum logic {
      LANE_BYTE = 1'b0,
      LANE_WORD = 1'b1
   } lane_mode_e;

   typedef struct packed {
      logic hrst_n;
      logic byte_n;
      logic we_n;
      logic oe_n;
      logic ce_n;
   } bus_ctl_t;

   localparam int CTL_W = $bits(bus_ctl_t);
endpackage

// File: rtl/flash_bus_sync.sv
module flash_bus_sync #(
   parameter int W = 5,
   parameter int STAGES = 2,
   parameter logic [W-1:0] RST_VAL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   if (STAGES < 1) begin : g_bad
      $error("flash_bus_sync: STAGES must be at least 1");
   end

   if (STAGES == 1) begin : g_single
      logic [W-1:0] r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) r <= RST_VAL;
         else        r <= d_i;
      end
      assign q_o = r;
   end else begin : g_chain
      logic [W-1:0] stg [STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg[0] <= RST_VAL;
         else        stg[0] <= d_i;
      end
      for (genvar i = 1; i < STAGES; i++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[i] <= RST_VAL;
            else        stg[i] <= stg[i-1];
         end
      end
      assign q_o = stg[STAGES-1];
   end
endmodule

// File: rtl/flash_bus_wr_capture.sv
module flash_bus_wr_capture #(
   parameter int ADDR_W = 19,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              qual_i,
   input  logic              host_ok_i,
   input  logic              byte_mode_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] dq_i,
   output logic              wr_valid_o,
   output logic [ADDR_W:0]   wr_addr_o,
   output logic [DATA_W-1:0] wr_data_o,
   output logic              wr_byte_o
);
   localparam int HALF = DATA_W / 2;

   logic qual_q, armed, opening, closing;

   assign opening = qual_i & ~qual_q;
   assign closing = ~qual_i & qual_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         qual_q     <= 1'b0;
         armed      <= 1'b0;
         wr_valid_o <= 1'b0;
         wr_addr_o  <= '0;
         wr_data_o  <= '0;
         wr_byte_o  <= 1'b0;
      end else begin
         qual_q     <= qual_i;
         wr_valid_o <= 1'b0;
         if (!host_ok_i) begin
            armed <= 1'b0;
         end else if (opening) begin
            armed     <= 1'b1;
            wr_byte_o <= byte_mode_i;
            wr_addr_o <= {addr_i, byte_mode_i & dq_i[DATA_W-1]};
         end else if (closing && armed) begin
            armed      <= 1'b0;
            wr_valid_o <= 1'b1;
            wr_data_o  <= wr_byte_o ? {{(DATA_W-HALF){1'b0}}, dq_i[HALF-1:0]} : dq_i;
         end
      end
   end
endmodule

// File: rtl/flash_bus_rd_drive.sv
module flash_bus_rd_drive #(
   parameter int DATA_W = 16
) (
   input  logic              rd_en_i,
   input  logic              byte_mode_i,
   input  logic              lsb_i,
   input  logic [DATA_W-1:0] rdata_i,
   output logic [DATA_W-1:0] dq_o,
   output logic [DATA_W-1:0] dq_oe_o
);
   localparam int HALF = DATA_W / 2;

   logic [HALF-1:0] sel_byte;
   assign sel_byte = lsb_i ? rdata_i[DATA_W-1:HALF] : rdata_i[HALF-1:0];

   for (genvar i = 0; i < DATA_W; i++) begin : g_lane
      if (i < HALF) begin : g_low
         assign dq_oe_o[i] = rd_en_i;
         assign dq_o[i]    = byte_mode_i ? sel_byte[i] : rdata_i[i];
      end else begin : g_high
         assign dq_oe_o[i] = rd_en_i & ~byte_mode_i;
         assign dq_o[i]    = byte_mode_i ? 1'b0 : rdata_i[i];
      end
   end
endmodule

// File: rtl/flash_bus_front.sv
module flash_bus_front
   import flash_bus_pkg::*;
#(
   parameter int ADDR_W = 19,
   parameter int DATA_W = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n_i,
   input  logic              oe_n_i,
   input  logic              we_n_i,
   input  logic              byte_n_i,
   input  logic              hrst_n_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] dq_i,
   output logic [DATA_W-1:0] dq_o,
   output logic [DATA_W-1:0] dq_oe_o,
   output logic [ADDR_W-1:0] arr_addr_o,
   input  logic [DATA_W-1:0] arr_rdata_i,
   output logic              wr_valid_o,
   output logic [ADDR_W:0]   wr_addr_o,
   output logic [DATA_W-1:0] wr_data_o,
   output logic              wr_byte_o
);
   if (DATA_W < 4 || (DATA_W % 2) != 0) begin : g_bad_w
      $error("flash_bus_front: DATA_W must be even and at least 4");
   end
   if (ADDR_W < 1) begin : g_bad_a
      $error("flash_bus_front: ADDR_W must be positive");
   end

   bus_ctl_t   ctl_raw, ctl_s;
   lane_mode_e lane;
   logic       host_ok, rd_en, wr_qual;

   assign ctl_raw = '{hrst_n: hrst_n_i, byte_n: byte_n_i, we_n: we_n_i,
                      oe_n: oe_n_i, ce_n: ce_n_i};

   flash_bus_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d_i  (ctl_raw),
      .q_o  (ctl_s)
   );

   assign lane    = lane_mode_e'(ctl_s.byte_n);
   assign host_ok = ctl_s.hrst_n;
   assign rd_en   = host_ok & ~ctl_s.ce_n & ~ctl_s.oe_n;
   assign wr_qual = host_ok & ~ctl_s.ce_n & ctl_s.oe_n & ~ctl_s.we_n;

   assign arr_addr_o = addr_i;

   flash_bus_wr_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
      .clk        (clk),
      .rst_n      (rst_n),
      .qual_i     (wr_qual),
      .host_ok_i  (host_ok),
      .byte_mode_i(lane == LANE_BYTE),
      .addr_i     (addr_i),
      .dq_i       (dq_i),
      .wr_valid_o (wr_valid_o),
      .wr_addr_o  (wr_addr_o),
      .wr_data_o  (wr_data_o),
      .wr_byte_o  (wr_byte_o)
   );

   flash_bus_rd_drive #(.DATA_W(DATA_W)) u_rd (
      .rd_en_i    (rd_en),
      .byte_mode_i(lane == LANE_BYTE),
      .lsb_i      (dq_i[DATA_W-1]),
      .rdata_i    (arr_rdata_i),
      .dq_o       (dq_o),
      .dq_oe_o    (dq_oe_o)
   );
endmodule

// File: rtl/flash_bus_front_chk.sv
module flash_bus_front_chk #(
   parameter int ADDR_W = 19,
   parameter int DATA_W = 16,
   parameter int SYNC_STAGES = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ce_n_i,
   input logic              oe_n_i,
   input logic              byte_n_i,
   input logic              hrst_n_i,
   input logic [DATA_W-1:0] dq_oe_o,
   input logic              wr_valid_o,
   input logic [ADDR_W:0]   wr_addr_o,
   input logic [DATA_W-1:0] wr_data_o
);
   localparam int HALF = DATA_W / 2;
   localparam int LIM  = SYNC_STAGES + 1;
   localparam int CW   = $clog2(LIM + 1) + 1;

   logic [CW-1:0] ce_hi, oe_hi, byte_lo, rst_lo;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ce_hi <= '0; oe_hi <= '0; byte_lo <= '0; rst_lo <= '0;
      end else begin
         ce_hi   <= !ce_n_i   ? '0 : (ce_hi   == CW'(LIM) ? ce_hi   : ce_hi + 1'b1);
         oe_hi   <= !oe_n_i   ? '0 : (oe_hi   == CW'(LIM) ? oe_hi   : oe_hi + 1'b1);
         byte_lo <= byte_n_i  ? '0 : (byte_lo == CW'(LIM) ? byte_lo : byte_lo + 1'b1);
         rst_lo  <= hrst_n_i  ? '0 : (rst_lo  == CW'(LIM) ? rst_lo  : rst_lo + 1'b1);
      end
   end

   p_lane_park_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_lo >= CW'(SYNC_STAGES)) |-> (dq_oe_o[DATA_W-1:HALF] == '0));
   p_ce_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ce_hi >= CW'(SYNC_STAGES)) |-> (dq_oe_o == '0));
   p_oe_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (oe_hi >= CW'(SYNC_STAGES)) |-> (dq_oe_o == '0));
   p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid_o |=> !wr_valid_o);
   p_data_with_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(wr_data_o) |-> wr_valid_o);
   p_host_rst_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_lo >= CW'(LIM)) |-> (dq_oe_o == '0 && !wr_valid_o));
endmodule

bind flash_bus_front flash_bus_front_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)
) u_chk (
   .clk(clk), .rst_n(rst_n), .ce_n_i(ce_n_i), .oe_n_i(oe_n_i),
   .byte_n_i(byte_n_i), .hrst_n_i(hrst_n_i), .dq_oe_o(dq_oe_o),
   .wr_valid_o(wr_valid_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o)
);

// File: tb/sim_flash_bus_front.sv
module sim_flash_bus_front;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 19;
   localparam int DW = 16;
   localparam int SS = 3;
   localparam int GAP = SS + 3;

   logic clk = 0, rst_n = 0;
   logic ce_n = 1, oe_n = 1, we_n = 1, byte_n = 1, hrst_n = 1;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] dq_in = '0;
   logic [DW-1:0] dq_out, dq_oe;
   logic [AW-1:0] arr_addr;
   logic [DW-1:0] arr_rdata;
   logic          wr_valid, wr_byte;
   logic [AW:0]   wr_addr;
   logic [DW-1:0] wr_data;
   int total = 0, bad = 0, pulses = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   assign arr_rdata = {arr_addr[7:0] ^ 8'h3C, arr_addr[7:0]};

   flash_bus_front #(.ADDR_W(AW), .DATA_W(DW), .SYNC_STAGES(SS)) u0 (
      .clk(clk), .rst_n(rst_n), .ce_n_i(ce_n), .oe_n_i(oe_n), .we_n_i(we_n),
      .byte_n_i(byte_n), .hrst_n_i(hrst_n), .addr_i(addr), .dq_i(dq_in),
      .dq_o(dq_out), .dq_oe_o(dq_oe), .arr_addr_o(arr_addr),
      .arr_rdata_i(arr_rdata), .wr_valid_o(wr_valid), .wr_addr_o(wr_addr),
      .wr_data_o(wr_data), .wr_byte_o(wr_byte)
   );

   always @(posedge clk) if (wr_valid) pulses <= pulses + 1;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic write_cycle(input logic bmode, input logic [AW-1:0] a,
                              input logic [DW-1:0] d, input logic ce_v, input logic oe_v);
      @(negedge clk);
      byte_n = ~bmode; addr = a; dq_in = d; ce_n = ce_v; oe_n = oe_v;
      wait_cyc(GAP);
      we_n = 0;
      wait_cyc(GAP);
      we_n = 1;
      wait_cyc(GAP);
      ce_n = 1; oe_n = 1;
      wait_cyc(GAP);
   endtask

   task automatic t_reset_state();
      check("R10 oe", 32'(dq_oe), 0);
      check("R10 valid", 32'(wr_valid), 0);
      check("R10 addr", 32'(wr_addr), 0);
      check("R10 data", 32'(wr_data), 0);
   endtask

   task automatic t_word_read();
      @(negedge clk);
      byte_n = 1; addr = 19'h12345; ce_n = 0; oe_n = 0;
      wait_cyc(GAP);
      check("R1 oe", 32'(dq_oe), 32'hFFFF);
      check("R1 data", 32'(dq_out), 32'h7945);
      check("R1 arr_addr", 32'(arr_addr), 32'h12345);
      ce_n = 1; oe_n = 1;
      wait_cyc(GAP);
   endtask

   task automatic t_byte_read();
      @(negedge clk);
      byte_n = 0; addr = 19'h000A7; dq_in = 16'h0000; ce_n = 0; oe_n = 0;
      wait_cyc(GAP);
      check("R2 oe", 32'(dq_oe), 32'h00FF);
      check("R2 low byte", 32'(dq_out[7:0]), 32'hA7);
      dq_in = 16'h8000;
      wait_cyc(1);
      check("R2 high byte", 32'(dq_out[7:0]), 32'hA7 ^ 32'h3C);
      ce_n = 1; oe_n = 1; byte_n = 1; dq_in = '0;
      wait_cyc(GAP);
   endtask

   task automatic t_enables_off();
      @(negedge clk);
      ce_n = 1; oe_n = 0;
      wait_cyc(GAP);
      check("R3 ce high", 32'(dq_oe), 0);
      ce_n = 0; oe_n = 1;
      wait_cyc(GAP);
      check("R4 oe high", 32'(dq_oe), 0);
      ce_n = 1;
      wait_cyc(GAP);
   endtask

   task automatic t_word_write();
      int p0 = pulses;
      write_cycle(1'b0, 19'h0ABCD, 16'hBEEF, 1'b0, 1'b1);
      check("R5 one pulse", 32'(pulses - p0), 1);
      check("R7 word addr", 32'(wr_addr), 32'h0ABCD << 1);
      check("R8 word data", 32'(wr_data), 32'hBEEF);
      check("R8 word flag", 32'(wr_byte), 0);
   endtask

   task automatic t_byte_write();
      int p0 = pulses;
      write_cycle(1'b1, 19'h00321, 16'hFF5A, 1'b0, 1'b1);
      check("R5 byte pulse", 32'(pulses - p0), 1);
      check("R7 byte addr", 32'(wr_addr), (32'h00321 << 1) | 1);
      check("R8 byte data", 32'(wr_data), 32'h005A);
      check("R8 byte flag", 32'(wr_byte), 1);
   endtask

   task automatic t_blocked_write();
      int p0 = pulses;
      write_cycle(1'b0, 19'h00111, 16'h1111, 1'b1, 1'b1);
      check("R6 ce high", 32'(pulses - p0), 0);
      write_cycle(1'b0, 19'h00222, 16'h2222, 1'b0, 1'b0);
      check("R6 oe low", 32'(pulses - p0), 0);
      check("R6 data kept", 32'(wr_data), 32'h005A);
   endtask

   task automatic t_addr_hold();
      int p0 = pulses;
      @(negedge clk);
      byte_n = 1; addr = 19'h04444; dq_in = 16'hC0DE; ce_n = 0; oe_n = 1;
      wait_cyc(GAP);
      we_n = 0;
      wait_cyc(GAP);
      addr = 19'h07777;
      wait_cyc(GAP);
      we_n = 1;
      wait_cyc(GAP);
      ce_n = 1;
      wait_cyc(GAP);
      check("R7 addr held", 32'(wr_addr), 32'h04444 << 1);
      check("R5 held pulse", 32'(pulses - p0), 1);
   endtask

   task automatic t_host_reset();
      int p0 = pulses;
      @(negedge clk);
      hrst_n = 0; ce_n = 0; oe_n = 0;
      wait_cyc(GAP);
      check("R9 oe off", 32'(dq_oe), 0);
      ce_n = 1; oe_n = 1;
      wait_cyc(GAP);
      write_cycle(1'b0, 19'h00555, 16'h5555, 1'b0, 1'b1);
      check("R9 write ignored", 32'(pulses - p0), 0);
      hrst_n = 1;
      wait_cyc(GAP);
      @(negedge clk);
      addr = 19'h00666; dq_in = 16'h6666; ce_n = 0; oe_n = 1;
      wait_cyc(GAP);
      we_n = 0;
      wait_cyc(GAP);
      hrst_n = 0;
      wait_cyc(GAP);
      we_n = 1;
      wait_cyc(GAP);
      ce_n = 1;
      wait_cyc(GAP);
      hrst_n = 1;
      wait_cyc(GAP);
      check("R9 aborted write", 32'(pulses - p0), 0);
      check("R9 data kept", 32'(wr_data), 32'hC0DE);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      wait_cyc(3);
      t_reset_state();
      rst_n = 1;
      wait_cyc(GAP);
      t_word_read();
      t_byte_read();
      t_enables_off();
      t_word_write();
      t_byte_write();
      t_blocked_write();
      t_addr_hold();
      t_host_reset();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule